// File: doc/BRIEF.md
# Audio Clock Power-Save Controller

This block watches the three clocks of an audio serial port (system clock, bit clock and frame clock), already resampled into a free-running reference clock domain. From their activity it decides whether the converter path may run. It drives three enables: one for the bias/reference block, one for the negative charge pump, and one for the DAC with its line driver. It also reports its current state.

If any clock is missing, the block falls back to standby: the DAC path is switched off and the charge pump and bias stay up. If the bit clock and the frame clock both sit low for longer than a selectable halt time, it drops to full power-down with everything off. It wakes up on its own when all clocks return. It also wakes when the bit and frame clocks run while the system clock is held at ground for a fixed number of frame periods. Wake-up enables the domains one by one, with a settle interval between steps. Software can also send the block to standby or power-down. Such a software sleep holds until software issues an explicit power-up command.

Top module: `aud_pwr_save_ctrl`

## Requirements
- R1: After reset, state_o is 0 (power-down) and all three enables are low; with no clocks running, it stays there.
- R2: A clock counts as present only while it has toggled within the last WDOG_CYC reference cycles. If a needed clock goes missing while running, the block enters standby: state_o=1, dac_en_o low, cp_en_o and bias_en_o high.
- R3: If bck_i and lrck_i are both low for L consecutive reference cycles, the block enters power-down (state_o=0, all enables low) on the following edge, whatever state it was in.
- R4: L depends on halt_sel_i as follows, with B = HALT_BASE: 0→B, 1→B/2, 2→B/4, 3→B/8, 4→2B, 5→4B, 6→8B, 7→16B.
- R5: Once all three clocks are present and no software sleep is pending, the block leaves power-down and later reaches state_o=4 (run) with every enable high. From standby it resumes without dropping bias or charge pump.
- R6: Wake-up from power-down raises bias_en_o first. cp_en_o follows exactly SETTLE cycles later, and dac_en_o exactly SETTLE cycles after that. The intermediate states are state_o=2 (bias only) and state_o=3 (bias and pump).
- R7: The block treats clocks as valid when the bit and frame clocks are present and the system clock is idle at 0 for FRAMES frame-clock rising edges. A system clock idle at 1 never counts as valid.
- R8: sw_stby_i=1 with sw_pdn_i=0 forces standby. sw_pdn_i=1 with sw_stby_i=0 forces power-down.
- R9: After a software sleep, the block stays out of run even when both command bits return to 0. Only a cycle with both sw_stby_i and sw_pdn_i high (the power-up command) releases it.
- R10: When a power-down condition and a standby condition arrive in the same cycle, power-down wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | System clock, sampled into clk domain |
| bck_i | input | 1 | Bit clock, sampled into clk domain |
| lrck_i | input | 1 | Frame clock, sampled into clk domain |
| sw_stby_i | input | 1 | Software standby command bit |
| sw_pdn_i | input | 1 | Software power-down command bit |
| halt_sel_i | input | 3 | Halt detection time code |
| dac_en_o | output | 1 | DAC and line driver enable |
| cp_en_o | output | 1 | Negative charge pump enable |
| bias_en_o | output | 1 | Bias/reference enable |
| state_o | output | 3 | 0 power-down, 1 standby, 2 bias settle, 3 pump settle, 4 run |

## Verification
The halt timer expiring and a software standby request can land on the same reference edge. Both then ask for a different sleep state. The bench finds the exact cycle in which the halt count reaches its limit, measured by sweeping every halt code and checking the expiry at L+1 cycles. It then raises the standby bit at the negative edge just before the expiry edge. The state sampled half a cycle after that edge must be power-down, not standby.

// File: rtl/aps_pkg.sv
// Shared types for the audio clock power-save controller.
package aps_pkg;
    // Clock index positions inside the presence vector
    localparam int CLK_SCK  = 0;
    localparam int CLK_BCK  = 1;
    localparam int CLK_LRCK = 2;
    localparam int NUM_CLK  = 3;

    // Power state; encoding is visible on state_o
    typedef enum logic [2:0] {
        ST_PDN       = 3'd0,
        ST_STBY      = 3'd1,
        ST_WAKE_BIAS = 3'd2,
        ST_WAKE_CP   = 3'd3,
        ST_RUN       = 3'd4
    } pwr_state_e;
endpackage

// File: rtl/aps_clk_watch.sv
// Activity watchdog for one sampled clock.
// Reports present while an edge (either polarity) has been seen within
// the last WDOG_CYC reference cycles. Assumes lvl_i is already synchronous.
module aps_clk_watch #(
    parameter int WDOG_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic present_o
);
    localparam int CW = $clog2(WDOG_CYC + 1);

    logic          prev_q;
    logic [CW-1:0] idle_q;
    logic          edge_w;

    assign edge_w    = lvl_i ^ prev_q;
    assign present_o = (idle_q < CW'(WDOG_CYC));

    // Track previous level and cycles since the last edge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            idle_q <= CW'(WDOG_CYC);
        end else begin
            prev_q <= lvl_i;
            if (edge_w)
                idle_q <= '0;
            else if (idle_q != CW'(WDOG_CYC))
                idle_q <= idle_q + 1'b1;
        end
    end

    // R2
    absent_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present_o) |-> $past(!edge_w));
endmodule

// File: rtl/aps_halt_timer.sv
// Halt detector: counts reference cycles with bit clock and frame clock
// both low and flags expiry once the count reaches the coded limit.
// Assumes HALT_BASE >= 8 so that every code yields a nonzero limit.
module aps_halt_timer #(
    parameter int HALT_BASE = 24_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bck_i,
    input  logic       lrck_i,
    input  logic [2:0] sel_i,
    output logic       halt_o
);
    localparam int HALT_MAX = HALT_BASE * 16;
    localparam int HW       = $clog2(HALT_MAX + 1);

    logic [HW-1:0] lim_w;
    logic [HW-1:0] cnt_q;

    // Map halt code to a cycle limit: 0 nominal, 1..3 shorter, 4..7 longer
    always_comb begin
        case (sel_i)
            3'd0:    lim_w = HW'(HALT_BASE);
            3'd1:    lim_w = HW'(HALT_BASE / 2);
            3'd2:    lim_w = HW'(HALT_BASE / 4);
            3'd3:    lim_w = HW'(HALT_BASE / 8);
            3'd4:    lim_w = HW'(HALT_BASE * 2);
            3'd5:    lim_w = HW'(HALT_BASE * 4);
            3'd6:    lim_w = HW'(HALT_BASE * 8);
            default: lim_w = HW'(HALT_MAX);
        endcase
    end

    // Count consecutive low cycles; any high level restarts the count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (bck_i || lrck_i)
            cnt_q <= '0;
        else if (cnt_q < lim_w)
            cnt_q <= cnt_q + 1'b1;
    end

    assign halt_o = (cnt_q >= lim_w);

    // R4
    halt_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) && $stable(sel_i) |-> $past(!bck_i && !lrck_i));
endmodule

// File: rtl/aps_gnd_frames.sv
// Grounded system clock qualifier: counts frame-clock rising edges while
// the system clock is absent and held at 0 and both serial clocks are
// present. Reports ok after FRAMES such edges.
module aps_gnd_frames #(
    parameter int FRAMES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic lrck_i,
    input  logic sck_pres_i,
    input  logic bck_pres_i,
    input  logic lrck_pres_i,
    output logic gnd_ok_o
);
    localparam int FW = $clog2(FRAMES + 1);

    logic          lr_prev_q;
    logic [FW-1:0] frm_q;
    logic          qual_w;
    logic          lr_rise_w;

    assign qual_w    = !sck_i && !sck_pres_i && bck_pres_i && lrck_pres_i;
    assign lr_rise_w = lrck_i && !lr_prev_q;
    assign gnd_ok_o  = (frm_q == FW'(FRAMES));

    // Count qualifying frame periods, cleared whenever the condition breaks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev_q <= 1'b0;
            frm_q     <= '0;
        end else begin
            lr_prev_q <= lrck_i;
            if (!qual_w)
                frm_q <= '0;
            else if (lr_rise_w && (frm_q != FW'(FRAMES)))
                frm_q <= frm_q + 1'b1;
        end
    end

    // R7
    gnd_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnd_ok_o) |-> $past(!sck_i));
endmodule

// File: rtl/aps_seq_fsm.sv
// Power state sequencer. Chooses between run, standby and power-down from
// clock validity, halt expiry and software commands, and walks wake-up
// through bias, then charge pump, then DAC with SETTLE cycles per step.
// Both command bits high is the software power-up command.
module aps_seq_fsm
    import aps_pkg::*;
#(
    parameter int SETTLE = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_ok_i,
    input  logic       halt_i,
    input  logic       sw_stby_i,
    input  logic       sw_pdn_i,
    output pwr_state_e state_o,
    output logic       bias_en_o,
    output logic       cp_en_o,
    output logic       dac_en_o
);
    localparam int SW = $clog2(SETTLE + 1);

    pwr_state_e    st_q, st_d;
    logic [SW-1:0] set_q;
    logic          lk_stby_q, lk_pdn_q;
    logic          sw_up_w, req_stby_w, req_pdn_w;
    logic          go_pdn_w, go_stby_w, settled_w;

    assign sw_up_w    = sw_stby_i && sw_pdn_i;
    assign req_stby_w = sw_stby_i && !sw_pdn_i;
    assign req_pdn_w  = sw_pdn_i && !sw_stby_i;
    assign go_pdn_w   = halt_i || req_pdn_w || (lk_pdn_q && !sw_up_w);
    assign go_stby_w  = !clk_ok_i || req_stby_w || (lk_stby_q && !sw_up_w);
    assign settled_w  = (set_q == SW'(SETTLE - 1));

    // Next-state choice; power-down always outranks standby
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_PDN:       if (!go_pdn_w && !go_stby_w) st_d = ST_WAKE_BIAS;
            ST_STBY:      if (go_pdn_w) st_d = ST_PDN;
                          else if (!go_stby_w) st_d = ST_WAKE_CP;
            ST_WAKE_BIAS: if (go_pdn_w || go_stby_w) st_d = ST_PDN;
                          else if (settled_w) st_d = ST_WAKE_CP;
            ST_WAKE_CP:   if (go_pdn_w) st_d = ST_PDN;
                          else if (go_stby_w) st_d = ST_STBY;
                          else if (settled_w) st_d = ST_RUN;
            ST_RUN:       if (go_pdn_w) st_d = ST_PDN;
                          else if (go_stby_w) st_d = ST_STBY;
            default:      st_d = ST_PDN;
        endcase
    end

    // State register and per-state settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_PDN;
            set_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                set_q <= '0;
            else if (!settled_w)
                set_q <= set_q + 1'b1;
        end
    end

    // Software sleep latches, released only by the power-up command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_stby_q <= 1'b0;
            lk_pdn_q  <= 1'b0;
        end else if (sw_up_w) begin
            lk_stby_q <= 1'b0;
            lk_pdn_q  <= 1'b0;
        end else begin
            lk_stby_q <= lk_stby_q || req_stby_w;
            lk_pdn_q  <= lk_pdn_q || req_pdn_w;
        end
    end

    assign state_o   = st_q;
    assign bias_en_o = (st_q != ST_PDN);
    assign cp_en_o   = (st_q == ST_STBY) || (st_q == ST_WAKE_CP) || (st_q == ST_RUN);
    assign dac_en_o  = (st_q == ST_RUN);

    // R3
    halt_to_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (st_q == ST_PDN));
    // R6
    cp_after_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_en_o) |-> $past(bias_en_o));
    // R6
    dac_after_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_en_o) |-> $past(cp_en_o));
    // R8
    sw_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pdn_i && !sw_stby_i) |=> (st_q == ST_PDN));
    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lk_stby_q || lk_pdn_q) && !sw_up_w && (st_q != ST_RUN)) |=> (st_q != ST_RUN));
endmodule

// File: rtl/aud_pwr_save_ctrl.sv
// Top of the audio clock power-save controller. Assumes all three audio
// clocks are already synchronised into the clk domain and toggle much
// slower than clk. Produces domain enables and the current power state.
module aud_pwr_save_ctrl
    import aps_pkg::*;
#(
    parameter int WDOG_CYC  = 64,
    parameter int HALT_BASE = 24_000_000,
    parameter int FRAMES    = 16,
    parameter int SETTLE    = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       bck_i,
    input  logic       lrck_i,
    input  logic       sw_stby_i,
    input  logic       sw_pdn_i,
    input  logic [2:0] halt_sel_i,
    output logic       dac_en_o,
    output logic       cp_en_o,
    output logic       bias_en_o,
    output logic [2:0] state_o
);
    logic [NUM_CLK-1:0] lvl_w;
    logic [NUM_CLK-1:0] pres_w;
    logic               halt_w;
    logic               gnd_ok_w;
    logic               clk_ok_w;
    pwr_state_e         st_w;

    assign lvl_w[CLK_SCK]  = sck_i;
    assign lvl_w[CLK_BCK]  = bck_i;
    assign lvl_w[CLK_LRCK] = lrck_i;

    // One activity watchdog per monitored clock
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_watch
        aps_clk_watch #(.WDOG_CYC(WDOG_CYC)) u_watch (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (lvl_w[g]),
            .present_o (pres_w[g])
        );
    end

    aps_halt_timer #(.HALT_BASE(HALT_BASE)) u_halt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bck_i  (bck_i),
        .lrck_i (lrck_i),
        .sel_i  (halt_sel_i),
        .halt_o (halt_w)
    );

    aps_gnd_frames #(.FRAMES(FRAMES)) u_gnd (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck_i),
        .lrck_i      (lrck_i),
        .sck_pres_i  (pres_w[CLK_SCK]),
        .bck_pres_i  (pres_w[CLK_BCK]),
        .lrck_pres_i (pres_w[CLK_LRCK]),
        .gnd_ok_o    (gnd_ok_w)
    );

    assign clk_ok_w = pres_w[CLK_BCK] && pres_w[CLK_LRCK] &&
                      (pres_w[CLK_SCK] || gnd_ok_w);

    aps_seq_fsm #(.SETTLE(SETTLE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_ok_i  (clk_ok_w),
        .halt_i    (halt_w),
        .sw_stby_i (sw_stby_i),
        .sw_pdn_i  (sw_pdn_i),
        .state_o   (st_w),
        .bias_en_o (bias_en_o),
        .cp_en_o   (cp_en_o),
        .dac_en_o  (dac_en_o)
    );

    assign state_o = st_w;

    // R2
    stby_on_missing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_ok_w && !halt_w && (st_w == ST_RUN)) |=> (state_o == 3'd1));
endmodule

// File: tb/tb_aud_pwr_save_ctrl.sv
module tb_aud_pwr_save_ctrl;
    localparam int CLK_PER = 10;
    localparam int WD  = 48;
    localparam int HB  = 64;
    localparam int FRM = 16;
    localparam int ST  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, bck = 1'b0, lrck = 1'b0;
    logic sw_stby = 1'b0, sw_pdn = 1'b0;
    logic [2:0] hsel = 3'd0;
    logic dac_en, cp_en, bias_en;
    logic [2:0] state;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    int ph = 0;
    bit en_s = 0, en_b = 0, en_l = 0;
    logic fs = 0, fb = 0, fl = 0;

    always #(CLK_PER/2) clk = ~clk;

    aud_pwr_save_ctrl #(.WDOG_CYC(WD), .HALT_BASE(HB), .FRAMES(FRM), .SETTLE(ST)) dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .bck_i(bck), .lrck_i(lrck),
        .sw_stby_i(sw_stby), .sw_pdn_i(sw_pdn), .halt_sel_i(hsel),
        .dac_en_o(dac_en), .cp_en_o(cp_en), .bias_en_o(bias_en), .state_o(state));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance n cycles; clock patterns are updated at each falling edge
    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ph++;
            sck  = en_s ? ph[0] : fs;
            bck  = en_b ? ph[1] : fb;
            lrck = en_l ? ph[4] : fl;
        end
    endtask

    task automatic all_clocks_on();
        en_s = 1; en_b = 1; en_l = 1;
    endtask

    task automatic wait_run(output int n);
        n = 0;
        while (state != 3'd4 && n < 5000) begin
            tick(1);
            n++;
        end
    endtask

    function automatic int halt_len(input int c);
        int r;
        case (c)
            0: r = HB;
            1: r = HB / 2;
            2: r = HB / 4;
            3: r = HB / 8;
            default: r = HB << (c - 3);
        endcase
        return r;
    endfunction

    // Stop both serial clocks low and count cycles until power-down
    task automatic halt_measure(input int stby_at, output int n);
        en_b = 0; en_l = 0; fb = 1; fl = 0;
        tick(1);
        fb = 0;
        tick(1);
        n = 0;
        for (int i = 1; i < 3000; i++) begin
            tick(1);
            if (state == 3'd0) begin n = i; break; end
            if (i == stby_at) sw_stby = 1;
        end
    endtask

    initial begin
        int n, ta, tb, tc;
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk(state == 3'd0, "R1 state", state, 0);
        chk({dac_en, cp_en, bias_en} == 3'b000, "R1 enables", {dac_en, cp_en, bias_en}, 0);
        tick(200);
        chk(state == 3'd0, "R1 idle stays down", state, 0);

        // R5 R6 wake-up ordering
        all_clocks_on();
        ta = -1; tb = -1; tc = -1;
        for (int i = 0; i < 600; i++) begin
            tick(1);
            if (bias_en && ta < 0) ta = i;
            if (cp_en && tb < 0) tb = i;
            if (dac_en && tc < 0) tc = i;
        end
        chk(tb - ta == ST, "R6 bias->cp", tb - ta, ST);
        chk(tc - tb == ST, "R6 cp->dac", tc - tb, ST);
        chk(state == 3'd4, "R5 run", state, 4);

        // R2 sck stuck high -> standby
        en_s = 0; fs = 1;
        tick(100);
        chk(state == 3'd1, "R2 standby state", state, 1);
        chk({dac_en, cp_en, bias_en} == 3'b011, "R2 standby enables", {dac_en, cp_en, bias_en}, 3);
        tick(1000);
        chk(state == 3'd1, "R7 stuck high not valid", state, 1);
        // R7 sck grounded
        fs = 0;
        tick(400);
        chk(state == 3'd1, "R7 before frames", state, 1);
        tick(600);
        chk(state == 3'd4, "R7 after frames", state, 4);
        en_s = 1;
        tick(100);
        chk(state == 3'd4, "R5 sck restored", state, 4);

        // R3 R4 sweep every halt code
        for (int c = 0; c < 8; c++) begin
            hsel = 3'(c);
            halt_measure(-1, n);
            chk(n == halt_len(c) + 1, "R4 halt length", n, halt_len(c) + 1);
            chk({dac_en, cp_en, bias_en} == 3'b000, "R3 pdn enables", {dac_en, cp_en, bias_en}, 0);
            all_clocks_on();
            wait_run(n);
            chk(state == 3'd4, "R5 resume after halt", state, 4);
        end

        // R10 halt expiry and standby request on the same edge
        hsel = 3'd3;
        halt_measure(halt_len(3), n);
        chk(state == 3'd0, "R10 pdn wins", state, 0);
        sw_stby = 0;
        all_clocks_on();
        tick(300);
        chk(state == 3'd0, "R9 locked after sw standby", state, 0);
        sw_stby = 1; sw_pdn = 1;
        tick(1);
        sw_stby = 0; sw_pdn = 0;
        wait_run(n);
        chk(state == 3'd4, "R9 power-up command", state, 4);

        // R8 R9 software standby
        sw_stby = 1;
        tick(5);
        chk(state == 3'd1, "R8 sw standby", state, 1);
        chk({dac_en, cp_en, bias_en} == 3'b011, "R8 sw standby enables", {dac_en, cp_en, bias_en}, 3);
        sw_stby = 0;
        tick(200);
        chk(state == 3'd1, "R9 standby held", state, 1);
        sw_stby = 1; sw_pdn = 1;
        tick(1);
        sw_stby = 0; sw_pdn = 0;
        tick(100);
        chk(state == 3'd4, "R9 released from standby", state, 4);

        // R8 R9 software power-down
        sw_pdn = 1;
        tick(5);
        chk(state == 3'd0, "R8 sw pdn", state, 0);
        sw_pdn = 0;
        tick(200);
        chk(state == 3'd0, "R9 pdn held", state, 0);
        sw_stby = 1; sw_pdn = 1;
        tick(1);
        sw_stby = 0; sw_pdn = 0;
        tick(100);
        chk(state == 3'd4, "R9 released from pdn", state, 4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule